// File: doc/BRIEF.md
# Two-Fetch Instruction Register

This block builds one 16-bit instruction word from two consecutive 8-bit transfers on a shared data bus. It holds the word for the decoder. The cycle controller raises a load enable on each clock in which the bus carries an instruction byte. An internal beat index records which half of the word the next qualified load writes. The first load of an instruction fills the upper byte and the second fills the lower byte. The index then wraps, so the next load starts a new instruction.

The held word is split into two fields. The top three bits form the operation code. The remaining thirteen bits form the operand address, which spans an 8 K byte space. An asynchronous active-low reset clears the word and points the index at the upper byte. Reset must be released away from a rising clock edge.

Top module: `twofetch_ir`

## Requirements
- R1: While `rst_n` is low, `opcode` reads 0, `operand_addr` reads 0, and the beat index points at the upper byte, so the first load after reset release fills bits 15:8.
- R2: A rising edge with `load_en` high and the index on the upper byte writes `bus_byte` into word bits 15:8. After that edge, `opcode` equals `bus_byte[7:5]`, `operand_addr[12:8]` equals `bus_byte[4:0]`, and `operand_addr[7:0]` keeps its value.
- R3: A rising edge with `load_en` high and the index on the lower byte writes `bus_byte` into word bits 7:0. After that edge, `operand_addr[7:0]` equals `bus_byte`, and `opcode` and `operand_addr[12:8]` keep their values.
- R4: A rising edge with `load_en` low changes neither output, whatever `bus_byte` carries.
- R5: The beat index advances only on a qualified load and alternates upper, lower, upper, and so on. Any number of idle clocks between the two halves leaves the pairing intact.
- R6: `opcode` is always word bits 15:13 and `operand_addr` is always word bits 12:0. A pair (H, L) therefore yields `opcode = H[7:5]` and `operand_addr = {H[4:0], L}`.
- R7: Reset asserted between the two halves of an instruction discards the partial word. The next load after release fills the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loads happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load qualifier from the cycle controller |
| bus_byte | input | 8 | Byte currently on the shared data bus |
| opcode | output | 3 | Operation code, word bits 15:13 |
| operand_addr | output | 13 | Operand address, word bits 12:0 |

## Verification
All-ones and all-zero pairs show whether each field reaches its full width and whether stale bits survive a load. Pairs with idle clocks inserted between the halves, and with the bus changing during those idle clocks, separate a toggle that is gated by the enable from one that runs freely. A reset between the halves shows whether the index returns to the upper byte. A long stretch of random enables and random bytes, compared after every clock with a bench model of the word, exercises the byte order and the field boundary at bit 13.

// File: rtl/twofetch_ir_pkg.sv
package twofetch_ir_pkg;
  localparam int BUS_W   = 8;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 3;
  localparam int BEATS   = INSTR_W / BUS_W;
  localparam int ADDR_W  = INSTR_W - OPC_W;
  localparam int IDX_W   = (BEATS > 1) ? $clog2(BEATS) : 1;
endpackage

// File: rtl/twofetch_ir_seq.sv
// Beat sequencer: tracks which bus-width slice of the word the next load fills.
module twofetch_ir_seq #(
  parameter int BEATS = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  output logic [IDX_W-1:0] beat_idx,
  output logic [BEATS-1:0] beat_we
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    idx_nxt = beat_idx;
    if (load_en) begin
      if (beat_idx == LAST) idx_nxt = '0;
      else                  idx_nxt = beat_idx + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < BEATS; i++)
      beat_we[i] = load_en && (beat_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_idx <= '0;
    else        beat_idx <= idx_nxt;
  end
endmodule

// File: rtl/twofetch_ir_store.sv
// Word storage: one bus-width slice per beat; beat 0 is the most significant.
module twofetch_ir_store #(
  parameter int BUS_W   = 8,
  parameter int BEATS   = 2,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BEATS-1:0]   beat_we,
  input  logic [BUS_W-1:0]   bus_byte,
  output logic [INSTR_W-1:0] word
);
  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    localparam int TOP = INSTR_W - 1 - g * BUS_W;
    logic [BUS_W-1:0] slice_q;
    logic [BUS_W-1:0] slice_d;

    always_comb begin
      slice_d = slice_q;
      if (beat_we[g]) slice_d = bus_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slice_q <= '0;
      else        slice_q <= slice_d;
    end

    assign word[TOP -: BUS_W] = slice_q;
  end
endmodule

// File: rtl/twofetch_ir_split.sv
// Field extraction: operation code on top, operand address below it.
module twofetch_ir_split #(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 3,
  parameter int ADDR_W  = 13
) (
  input  logic [INSTR_W-1:0] word,
  output logic [OPC_W-1:0]   opcode,
  output logic [ADDR_W-1:0]  operand_addr
);
  assign opcode       = word[INSTR_W-1 -: OPC_W];
  assign operand_addr = word[ADDR_W-1:0];
endmodule

// File: rtl/twofetch_ir.sv
module twofetch_ir
  import twofetch_ir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BUS_W-1:0]  bus_byte,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] operand_addr
);
  logic [IDX_W-1:0]   beat_idx;
  logic [BEATS-1:0]   beat_we;
  logic [INSTR_W-1:0] word;

  twofetch_ir_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .beat_idx (beat_idx),
    .beat_we  (beat_we)
  );

  twofetch_ir_store #(.BUS_W(BUS_W), .BEATS(BEATS), .INSTR_W(INSTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_we  (beat_we),
    .bus_byte (bus_byte),
    .word     (word)
  );

  twofetch_ir_split #(.INSTR_W(INSTR_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_split (
    .word         (word),
    .opcode       (opcode),
    .operand_addr (operand_addr)
  );
endmodule

// File: rtl/twofetch_ir_chk.sv
module twofetch_ir_chk
  import twofetch_ir_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic [BUS_W-1:0]  bus_byte,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] operand_addr,
  input logic [IDX_W-1:0]  beat_idx
);
  logic [INSTR_W-1:0] obs_word;
  logic               upper_next;
  assign obs_word   = {opcode, operand_addr};
  assign upper_next = (beat_idx == '0);

  // R1, R7: reset clears the word and points the index at the upper byte
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (obs_word == '0 && upper_next)
        else $error("a_r1_reset_clear");
    end
  end

  // R2, R6: an upper-byte load fills bits 15:8 and leaves bits 7:0 alone
  a_r2_upper_fill: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && upper_next |=>
      obs_word[INSTR_W-1 -: BUS_W] == $past(bus_byte) &&
      obs_word[BUS_W-1:0] == $past(obs_word[BUS_W-1:0]));

  // R3, R6: a lower-byte load fills bits 7:0 and leaves bits 15:8 alone
  a_r3_lower_fill: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !upper_next |=>
      obs_word[BUS_W-1:0] == $past(bus_byte) &&
      obs_word[INSTR_W-1 -: BUS_W] == $past(obs_word[INSTR_W-1 -: BUS_W]));

  // R4: no load, no change on the outputs
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(opcode) && $stable(operand_addr));

  // R5: the index moves on every load and only on a load
  a_r5_idx_moves: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> beat_idx != $past(beat_idx));
  a_r5_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(beat_idx));
endmodule

bind twofetch_ir twofetch_ir_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_en      (load_en),
  .bus_byte     (bus_byte),
  .opcode       (opcode),
  .operand_addr (operand_addr),
  .beat_idx     (beat_idx)
);

// File: tb/tb_twofetch_ir.sv
`timescale 1ns/1ps
module tb_twofetch_ir;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [7:0]  bus_byte;
  logic [2:0]  opcode;
  logic [12:0] operand_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] m_word;
  bit          m_lower;

  always #4 clk = ~clk;

  twofetch_ir dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .bus_byte(bus_byte),
    .opcode(opcode), .operand_addr(operand_addr)
  );

  function automatic logic [2:0] exp_opc(input logic [15:0] w);
    return w[15:13];
  endfunction
  function automatic logic [12:0] exp_addr(input logic [15:0] w);
    return w[12:0];
  endfunction

  task automatic check_out(input string req);
    checks++;
    if (opcode !== exp_opc(m_word) || operand_addr !== exp_addr(m_word)) begin
      failures++;
      $display("FAIL %s: opcode=%0h addr=%0h expected opcode=%0h addr=%0h",
               req, opcode, operand_addr, exp_opc(m_word), exp_addr(m_word));
    end
  endtask

  // one clock: drive at the falling edge, update the model at the rising edge,
  // sample at the next falling edge
  task automatic step(input bit en, input logic [7:0] b);
    @(negedge clk);
    load_en  = en;
    bus_byte = b;
    @(posedge clk);
    if (en) begin
      if (!m_lower) m_word[15:8] = b;
      else          m_word[7:0]  = b;
      m_lower = !m_lower;
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_word = '0;
    m_lower = 0;
    #1;
    check_out("R1 reset clear");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; load_en = 1'b0; bus_byte = '0;
    m_word = '0; m_lower = 0;
    #1 rst_n = 1'b0;
    #1;
    check_out("R1 reset state");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2, R6: all-ones pair
    step(1, 8'hFF); check_out("R2 upper fill ones");
    step(1, 8'hFF); check_out("R6 full ones op=7 addr=1fff");
    // R2, R3: all-zero pair clears stale bits
    step(1, 8'h00); check_out("R2 upper zeros keep low");
    step(1, 8'h00); check_out("R3 lower zeros");
    // R6: field boundary at bit 13
    step(1, 8'hA3); step(1, 8'h5C); check_out("R6 pair a3 5c");
    // R4, R5: idle gap with a noisy bus between halves
    step(1, 8'h2E); check_out("R2 upper before gap");
    for (int i = 0; i < 5; i++) begin
      step(0, 8'(i * 37 + 11)); check_out("R4 idle hold");
    end
    step(1, 8'h91); check_out("R5 lower after gap");
    step(1, 8'hC0); check_out("R5 next instr upper");
    // R7: reset between halves
    do_reset();
    step(1, 8'h7B); check_out("R7 upper after mid reset");
    step(1, 8'h44); check_out("R7 lower after mid reset");

    // random stretch
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) != 0, 8'($urandom));
      check_out("R5 random sequence");
      if ((i % 150) == 149) do_reset();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule